// File: doc/BRIEF.md
# Bus Watchpoint Comparator Set

This block watches a processor bus and raises match pulses for a downstream sequencer. Every valid bus cycle presents an address, a 16-bit data word, a read/write indication and a byte/word size indication. Three comparator units judge that cycle against their own programmed values:

- Unit A compares the address and the data bus, and a mask selects which data bits count.
- Unit B compares the address and can also be restricted to one access size.
- Unit C compares the address only.

Each unit can be restricted to read cycles only or to write cycles only. Units A and B can be joined into a range detector. Unit A's address is then the lower bound and unit B's address the upper bound. The detector fires either for addresses inside the bounds or for addresses outside them. The combined result appears on unit A's output, and unit B's own output stays quiet.

Software programs the units through a plain write port of eight word-wide registers. The match outputs are registered: each is a one-cycle pulse in the clock cycle that follows the bus cycle that caused it.

Top module: `bus_watch_cmp`

## Requirements
- R1: After reset, all registers hold zero and `hit_a`, `hit_b` and `hit_c` are 0, so no comparator fires until it is programmed.
- R2: Simple match on unit A: `hit_a` fires when the bus address equals the register at offset 1, and the bus data agrees with the register at offset 2 on every bit where the mask register at offset 3 holds 1. A mask of all zeros makes the data check always pass.
- R3: Direction qualifier on any unit: control bit 1 enables the check and control bit 2 selects the direction. A 1 in bit 2 accepts only read cycles (`bus_rd`=1); a 0 accepts only write cycles. With bit 1 clear, both directions match.
- R4: Size qualifier on unit B (control register at offset 4): bit 3 enables the check and bit 4 selects the size. A 1 in bit 4 accepts only word cycles (`bus_word`=1); a 0 accepts only byte cycles.
- R5: Unit C (control at offset 6, address at offset 7) fires `hit_c` only when the bus address equals its address register.
- R6: Inside range: unit A control bits 3=1 and 4=0 make `hit_a` fire when A-address ≤ bus address ≤ B-address (offset 5), with both ends inclusive. Unit A's enable, direction and data checks still apply.
- R7: Outside range: unit A control bits 3=1 and 4=1 make `hit_a` fire when the bus address is below the A-address or above the B-address.
- R8: While range mode is on (unit A control bit 3), `hit_b` stays 0 even for a cycle that matches unit B exactly.
- R9: A hit appears only in the cycle after a bus cycle with `bus_vld`=1, lasts one cycle, and needs the unit's enable (control bit 0) to be 1.
- R10: A register write in the same cycle as a bus cycle takes effect for the next cycle. That bus cycle is judged against the old register contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register offset |
| cfg_wdata | input | 16 | Register write data |
| bus_vld | input | 1 | Bus cycle valid |
| bus_addr | input | 16 | Bus address |
| bus_data | input | 16 | Bus data |
| bus_rd | input | 1 | 1 = read cycle, 0 = write cycle |
| bus_word | input | 1 | 1 = word access, 0 = byte access |
| hit_a | output | 1 | Unit A (or range) match pulse |
| hit_b | output | 1 | Unit B match pulse |
| hit_c | output | 1 | Unit C match pulse |

## Verification
Two functions can land in the same cycle: a register write and a bus cycle that the written register decides. The bench provokes this by retargeting unit A's address while a bus cycle to the old address is presented in the same clock. It expects a hit from the old value, then no hit for the old address and a hit for the new one in the following cycles. A second overlap exists because range mode draws on unit B's register while unit B's own match is suppressed. This is judged by placing a bus cycle exactly on B's address, which is also the upper bound, and requiring `hit_a` high and `hit_b` low.

// File: rtl/bwc_pkg.sv
package bwc_pkg;
   localparam int unsigned CTL_W      = 5;
   localparam int unsigned CB_EN      = 0;
   localparam int unsigned CB_RWCHK   = 1;
   localparam int unsigned CB_RWRD    = 2;
   localparam int unsigned CB_OPT3    = 3;
   localparam int unsigned CB_OPT4    = 4;

   localparam int unsigned OFS_A_CTL  = 0;
   localparam int unsigned OFS_A_ADR  = 1;
   localparam int unsigned OFS_A_DAT  = 2;
   localparam int unsigned OFS_A_MSK  = 3;
   localparam int unsigned OFS_B_CTL  = 4;
   localparam int unsigned OFS_B_ADR  = 5;
   localparam int unsigned OFS_C_CTL  = 6;
   localparam int unsigned OFS_C_ADR  = 7;

   typedef struct packed {
      logic en;
      logic rw_chk;
      logic rw_rd;
      logic sz_chk;
      logic sz_word;
      logic rng_en;
      logic rng_out;
   } cmp_ctl_t;
endpackage

// File: rtl/bwc_regs.sv
module bwc_regs
   import bwc_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 16,
   parameter int RA_W   = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [RA_W-1:0]   waddr,
   input  logic [DATA_W-1:0] wdata,
   output cmp_ctl_t          a_ctl,
   output cmp_ctl_t          b_ctl,
   output cmp_ctl_t          c_ctl,
   output logic [ADDR_W-1:0] a_addr,
   output logic [ADDR_W-1:0] b_addr,
   output logic [ADDR_W-1:0] c_addr,
   output logic [DATA_W-1:0] a_data,
   output logic [DATA_W-1:0] a_mask
);
   localparam int NREG = 8;

   if (ADDR_W > DATA_W) begin : g_chk_aw
      $error("bwc_regs: ADDR_W must not exceed DATA_W");
   end
   if ((1 << RA_W) < NREG) begin : g_chk_ra
      $error("bwc_regs: RA_W too small for register map");
   end

   logic [CTL_W-1:0] a_ctl_q, b_ctl_q, c_ctl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         a_ctl_q <= '0;
         b_ctl_q <= '0;
         c_ctl_q <= '0;
         a_addr  <= '0;
         b_addr  <= '0;
         c_addr  <= '0;
         a_data  <= '0;
         a_mask  <= '0;
      end else if (we) begin
         case (waddr)
            RA_W'(OFS_A_CTL): a_ctl_q <= wdata[CTL_W-1:0];
            RA_W'(OFS_A_ADR): a_addr  <= wdata[ADDR_W-1:0];
            RA_W'(OFS_A_DAT): a_data  <= wdata;
            RA_W'(OFS_A_MSK): a_mask  <= wdata;
            RA_W'(OFS_B_CTL): b_ctl_q <= wdata[CTL_W-1:0];
            RA_W'(OFS_B_ADR): b_addr  <= wdata[ADDR_W-1:0];
            RA_W'(OFS_C_CTL): c_ctl_q <= wdata[CTL_W-1:0];
            RA_W'(OFS_C_ADR): c_addr  <= wdata[ADDR_W-1:0];
            default: ;
         endcase
      end
   end

   always_comb begin
      a_ctl = '{en: a_ctl_q[CB_EN], rw_chk: a_ctl_q[CB_RWCHK], rw_rd: a_ctl_q[CB_RWRD],
                sz_chk: 1'b0, sz_word: 1'b0,
                rng_en: a_ctl_q[CB_OPT3], rng_out: a_ctl_q[CB_OPT4]};
      b_ctl = '{en: b_ctl_q[CB_EN], rw_chk: b_ctl_q[CB_RWCHK], rw_rd: b_ctl_q[CB_RWRD],
                sz_chk: b_ctl_q[CB_OPT3], sz_word: b_ctl_q[CB_OPT4],
                rng_en: 1'b0, rng_out: 1'b0};
      c_ctl = '{en: c_ctl_q[CB_EN], rw_chk: c_ctl_q[CB_RWCHK], rw_rd: c_ctl_q[CB_RWRD],
                sz_chk: 1'b0, sz_word: 1'b0, rng_en: 1'b0, rng_out: 1'b0};
   end

   logic unused_hi;
   if (DATA_W > ADDR_W) begin : g_unused_hi
      assign unused_hi = ^wdata[DATA_W-1:ADDR_W];
   end else begin : g_no_unused_hi
      assign unused_hi = 1'b0;
   end

   // R10
   a_addr_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (we && waddr == RA_W'(OFS_A_ADR)) |=> (a_addr == $past(wdata[ADDR_W-1:0])));

   // R10
   c_addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!we || waddr != RA_W'(OFS_C_ADR)) |=> $stable(c_addr));
endmodule

// File: rtl/bwc_unit.sv
module bwc_unit
   import bwc_pkg::*;
#(
   parameter int ADDR_W   = 16,
   parameter int DATA_W   = 16,
   parameter bit HAS_DATA = 1'b0,
   parameter bit HAS_SIZE = 1'b0
) (
   input  cmp_ctl_t          ctl,
   input  logic [ADDR_W-1:0] ref_addr,
   input  logic [DATA_W-1:0] ref_data,
   input  logic [DATA_W-1:0] ref_mask,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_data,
   input  logic              bus_rd,
   input  logic              bus_word,
   output logic              addr_eq,
   output logic              qual_ok
);
   logic rw_ok, sz_ok, dat_ok;

   assign addr_eq = (bus_addr == ref_addr);
   assign rw_ok   = !ctl.rw_chk || (ctl.rw_rd == bus_rd);

   if (HAS_DATA) begin : g_data
      assign dat_ok = (((bus_data ^ ref_data) & ref_mask) == '0);
   end else begin : g_nodata
      logic unused_d;
      assign unused_d = ^{ref_data, ref_mask, bus_data};
      assign dat_ok   = 1'b1;
   end

   if (HAS_SIZE) begin : g_size
      assign sz_ok = !ctl.sz_chk || (ctl.sz_word == bus_word);
   end else begin : g_nosize
      logic unused_s;
      assign unused_s = bus_word ^ ctl.sz_chk ^ ctl.sz_word;
      assign sz_ok    = 1'b1;
   end

   logic unused_c;
   assign unused_c = ctl.en ^ ctl.rng_en ^ ctl.rng_out;

   assign qual_ok = rw_ok && sz_ok && dat_ok;
endmodule

// File: rtl/bwc_range.sv
module bwc_range #(
   parameter int ADDR_W = 16
) (
   input  logic [ADDR_W-1:0] lo,
   input  logic [ADDR_W-1:0] hi,
   input  logic [ADDR_W-1:0] addr,
   input  logic              outside,
   output logic              hit
);
   logic below, above;
   assign below = (addr < lo);
   assign above = (addr > hi);
   assign hit   = outside ? (below || above) : (!below && !above);
endmodule

// File: rtl/bus_watch_cmp.sv
module bus_watch_cmp
   import bwc_pkg::*;
#(
   parameter int ADDR_W    = 16,
   parameter int DATA_W    = 16,
   parameter int RA_W      = 4,
   parameter bit HAS_RANGE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [RA_W-1:0]   cfg_addr,
   input  logic [DATA_W-1:0] cfg_wdata,
   input  logic              bus_vld,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_data,
   input  logic              bus_rd,
   input  logic              bus_word,
   output logic              hit_a,
   output logic              hit_b,
   output logic              hit_c
);
   if (ADDR_W < 1 || ADDR_W > 32) begin : g_chk_aw
      $error("bus_watch_cmp: ADDR_W out of range");
   end
   if (DATA_W < 1 || DATA_W > 64) begin : g_chk_dw
      $error("bus_watch_cmp: DATA_W out of range");
   end

   cmp_ctl_t          a_ctl, b_ctl, c_ctl;
   logic [ADDR_W-1:0] a_addr, b_addr, c_addr;
   logic [DATA_W-1:0] a_data, a_mask;

   bwc_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .RA_W(RA_W)) regs_i (
      .clk(clk), .rst_n(rst_n), .we(cfg_we), .waddr(cfg_addr), .wdata(cfg_wdata),
      .a_ctl(a_ctl), .b_ctl(b_ctl), .c_ctl(c_ctl),
      .a_addr(a_addr), .b_addr(b_addr), .c_addr(c_addr),
      .a_data(a_data), .a_mask(a_mask)
   );

   logic a_eq, a_ok, b_eq, b_ok, c_eq, c_ok;

   bwc_unit #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .HAS_DATA(1'b1), .HAS_SIZE(1'b0)) unit_a_i (
      .ctl(a_ctl), .ref_addr(a_addr), .ref_data(a_data), .ref_mask(a_mask),
      .bus_addr(bus_addr), .bus_data(bus_data), .bus_rd(bus_rd), .bus_word(bus_word),
      .addr_eq(a_eq), .qual_ok(a_ok)
   );
   bwc_unit #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .HAS_DATA(1'b0), .HAS_SIZE(1'b1)) unit_b_i (
      .ctl(b_ctl), .ref_addr(b_addr), .ref_data('0), .ref_mask('0),
      .bus_addr(bus_addr), .bus_data(bus_data), .bus_rd(bus_rd), .bus_word(bus_word),
      .addr_eq(b_eq), .qual_ok(b_ok)
   );
   bwc_unit #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .HAS_DATA(1'b0), .HAS_SIZE(1'b0)) unit_c_i (
      .ctl(c_ctl), .ref_addr(c_addr), .ref_data('0), .ref_mask('0),
      .bus_addr(bus_addr), .bus_data(bus_data), .bus_rd(bus_rd), .bus_word(bus_word),
      .addr_eq(c_eq), .qual_ok(c_ok)
   );

   logic rng_on, rng_hit;

   if (HAS_RANGE) begin : g_range
      assign rng_on = a_ctl.rng_en;
      bwc_range #(.ADDR_W(ADDR_W)) range_i (
         .lo(a_addr), .hi(b_addr), .addr(bus_addr), .outside(a_ctl.rng_out), .hit(rng_hit)
      );
   end else begin : g_norange
      logic unused_r;
      assign unused_r = a_ctl.rng_en ^ a_ctl.rng_out;
      assign rng_on   = 1'b0;
      assign rng_hit  = 1'b0;
   end

   logic a_raw, b_raw, c_raw;
   assign a_raw = a_ctl.en && a_ok && (rng_on ? rng_hit : a_eq);
   assign b_raw = b_ctl.en && b_ok && b_eq && !rng_on;
   assign c_raw = c_ctl.en && c_ok && c_eq;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hit_a <= 1'b0;
         hit_b <= 1'b0;
         hit_c <= 1'b0;
      end else begin
         hit_a <= bus_vld && a_raw;
         hit_b <= bus_vld && b_raw;
         hit_c <= bus_vld && c_raw;
      end
   end

   // R9
   idle_no_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_vld |=> (!hit_a && !hit_b && !hit_c));

   // R8
   range_b_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rng_on |=> !hit_b);

   // R5
   hit_c_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hit_c |-> ($past(bus_addr) == $past(c_addr)));

   // R2
   hit_a_simple_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_a && !$past(rng_on)) |-> ($past(bus_addr) == $past(a_addr)));

   // R6
   hit_a_inside_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_a && $past(rng_on) && !$past(a_ctl.rng_out))
         |-> ($past(bus_addr) >= $past(a_addr) && $past(bus_addr) <= $past(b_addr)));

   // R9
   hit_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hit_b |-> $past(b_ctl.en));
endmodule

// File: tb/bus_watch_cmp_tb.sv
module bus_watch_cmp_tb_top;
   localparam time CLK_PERIOD = 10ns;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [3:0]  cfg_addr = '0;
   logic [15:0] cfg_wdata = '0;
   logic        bus_vld = 1'b0;
   logic [15:0] bus_addr = '0;
   logic [15:0] bus_data = '0;
   logic        bus_rd = 1'b0;
   logic        bus_word = 1'b0;
   logic        hit_a, hit_b, hit_c;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   bus_watch_cmp dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
      .bus_vld(bus_vld), .bus_addr(bus_addr), .bus_data(bus_data), .bus_rd(bus_rd),
      .bus_word(bus_word), .hit_a(hit_a), .hit_b(hit_b), .hit_c(hit_c)
   );

   task automatic check(input string req, input string what, input logic got, input logic exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%b expected=%b", req, what, got, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [15:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   // drive one bus cycle; on return the registered hits of that cycle are visible
   task automatic cyc(input logic v, input logic [15:0] a, input logic [15:0] d,
                      input logic rd, input logic wd);
      @(negedge clk);
      bus_vld = v; bus_addr = a; bus_data = d; bus_rd = rd; bus_word = wd;
      @(negedge clk);
      bus_vld = 1'b0;
   endtask

   task automatic t_reset;
      check("R1", "hit_a after reset", hit_a, 1'b0);
      check("R1", "hit_b after reset", hit_b, 1'b0);
      check("R1", "hit_c after reset", hit_c, 1'b0);
      cyc(1'b1, 16'h0000, 16'h0000, 1'b1, 1'b1);
      check("R1", "hit_a unprogrammed", hit_a, 1'b0);
      check("R1", "hit_c unprogrammed", hit_c, 1'b0);
   endtask

   task automatic t_simple_a;
      wr(4'd1, 16'h1234); wr(4'd2, 16'hAB00); wr(4'd3, 16'hFF00); wr(4'd0, 16'h0001);
      cyc(1'b1, 16'h1234, 16'hABCD, 1'b1, 1'b1);
      check("R2", "masked data equal", hit_a, 1'b1);
      cyc(1'b1, 16'h1234, 16'hAC00, 1'b1, 1'b1);
      check("R2", "masked data differs", hit_a, 1'b0);
      cyc(1'b1, 16'h1235, 16'hABCD, 1'b1, 1'b1);
      check("R2", "address differs", hit_a, 1'b0);
      wr(4'd3, 16'h0000);
      cyc(1'b1, 16'h1234, 16'h0000, 1'b0, 1'b0);
      check("R2", "zero mask ignores data", hit_a, 1'b1);
   endtask

   task automatic t_dir;
      wr(4'd0, 16'h0007);
      cyc(1'b1, 16'h1234, 16'h0000, 1'b0, 1'b1);
      check("R3", "read-only vs write", hit_a, 1'b0);
      cyc(1'b1, 16'h1234, 16'h0000, 1'b1, 1'b1);
      check("R3", "read-only vs read", hit_a, 1'b1);
      wr(4'd0, 16'h0003);
      cyc(1'b1, 16'h1234, 16'h0000, 1'b1, 1'b1);
      check("R3", "write-only vs read", hit_a, 1'b0);
      cyc(1'b1, 16'h1234, 16'h0000, 1'b0, 1'b1);
      check("R3", "write-only vs write", hit_a, 1'b1);
      wr(4'd0, 16'h0000);
   endtask

   task automatic t_size_b;
      wr(4'd5, 16'h2000); wr(4'd4, 16'h0019);
      cyc(1'b1, 16'h2000, 16'h0000, 1'b1, 1'b0);
      check("R4", "word-only vs byte", hit_b, 1'b0);
      cyc(1'b1, 16'h2000, 16'h0000, 1'b1, 1'b1);
      check("R4", "word-only vs word", hit_b, 1'b1);
      wr(4'd4, 16'h0009);
      cyc(1'b1, 16'h2000, 16'h0000, 1'b1, 1'b1);
      check("R4", "byte-only vs word", hit_b, 1'b0);
      cyc(1'b1, 16'h2000, 16'h0000, 1'b0, 1'b0);
      check("R4", "byte-only vs byte", hit_b, 1'b1);
      wr(4'd4, 16'h0001);
   endtask

   task automatic t_unit_c;
      wr(4'd7, 16'h3000); wr(4'd6, 16'h0001);
      cyc(1'b1, 16'h3000, 16'hFFFF, 1'b1, 1'b0);
      check("R5", "address equal", hit_c, 1'b1);
      cyc(1'b1, 16'h3001, 16'hFFFF, 1'b1, 1'b0);
      check("R5", "address off by one", hit_c, 1'b0);
   endtask

   task automatic t_qualify;
      cyc(1'b1, 16'h3000, 16'h0000, 1'b0, 1'b0);
      check("R9", "hit pulse present", hit_c, 1'b1);
      @(negedge clk);
      check("R9", "pulse lasts one cycle", hit_c, 1'b0);
      cyc(1'b0, 16'h3000, 16'h0000, 1'b0, 1'b0);
      check("R9", "bus_vld low", hit_c, 1'b0);
      wr(4'd6, 16'h0000);
      cyc(1'b1, 16'h3000, 16'h0000, 1'b0, 1'b0);
      check("R9", "unit disabled", hit_c, 1'b0);
   endtask

   task automatic t_range;
      wr(4'd1, 16'h0100); wr(4'd5, 16'h01FF); wr(4'd3, 16'h0000);
      wr(4'd4, 16'h0001); wr(4'd0, 16'h0009);
      cyc(1'b1, 16'h00FF, 16'h0000, 1'b1, 1'b1);
      check("R6", "below min", hit_a, 1'b0);
      cyc(1'b1, 16'h0100, 16'h0000, 1'b1, 1'b1);
      check("R6", "at min", hit_a, 1'b1);
      cyc(1'b1, 16'h01FF, 16'h0000, 1'b1, 1'b1);
      check("R6", "at max", hit_a, 1'b1);
      check("R8", "hit_b suppressed at B address", hit_b, 1'b0);
      cyc(1'b1, 16'h0200, 16'h0000, 1'b1, 1'b1);
      check("R6", "above max", hit_a, 1'b0);
      wr(4'd0, 16'h0019);
      cyc(1'b1, 16'h00FF, 16'h0000, 1'b1, 1'b1);
      check("R7", "below min", hit_a, 1'b1);
      cyc(1'b1, 16'h0100, 16'h0000, 1'b1, 1'b1);
      check("R7", "at min", hit_a, 1'b0);
      cyc(1'b1, 16'h01FF, 16'h0000, 1'b1, 1'b1);
      check("R7", "at max", hit_a, 1'b0);
      cyc(1'b1, 16'h0200, 16'h0000, 1'b1, 1'b1);
      check("R7", "above max", hit_a, 1'b1);
      wr(4'd0, 16'h0000);
      cyc(1'b1, 16'h01FF, 16'h0000, 1'b1, 1'b1);
      check("R8", "hit_b back after range off", hit_b, 1'b1);
   endtask

   task automatic t_overlap;
      wr(4'd1, 16'h4000); wr(4'd0, 16'h0001);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = 4'd1; cfg_wdata = 16'h5000;
      bus_vld = 1'b1; bus_addr = 16'h4000; bus_rd = 1'b1;
      @(negedge clk);
      cfg_we = 1'b0; bus_vld = 1'b0;
      check("R10", "same-cycle write uses old address", hit_a, 1'b1);
      cyc(1'b1, 16'h4000, 16'h0000, 1'b1, 1'b1);
      check("R10", "old address after write", hit_a, 1'b0);
      cyc(1'b1, 16'h5000, 16'h0000, 1'b1, 1'b1);
      check("R10", "new address after write", hit_a, 1'b1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset;
      t_simple_a;
      t_dir;
      t_size_b;
      t_unit_c;
      t_qualify;
      t_range;
      t_overlap;
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog R1 actual=running expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule